// File: doc/BRIEF.md
# Parallel Punctured Convolutional Encoder

This block turns a stream of data bits into a stream of forward-error-correction coded bits. Each data bit passes through a rate-1/2 convolutional code with seven taps. The coded stream is then thinned by a fixed deletion pattern to give an effective code rate of 1/2, 2/3 or 3/4. A parameter sets how many data bits arrive in one beat, and all of them are encoded in the same clock. Each coded bit is the parity of a fixed tap mask applied to the recent bit history. Because no coded bit depends on another, one mask per coded bit is applied in parallel, and the deletion step works on the same combinational path.

Data arrives on a valid/ready handshake. A start-of-frame flag on a beat clears the code memory and restarts the deletion pattern before that beat is encoded. The rate is captured on that beat and holds for the rest of the frame. Every accepted beat gives exactly one output beat one cycle later. The output beat holds the surviving coded bits packed from bit 0 upward and a count of how many are valid. Deleted bits are never emitted.

Top module: `conv_punct_enc`

## Requirements
- R1: With the code memory m1..m6 holding the previous six data bits (m1 the newest), the first coded bit of a data bit b is b^m2^m3^m5^m6 (generator 133 octal) and the second is b^m1^m2^m3^m6 (generator 171 octal). Within a beat, in_bits[0] is the earliest data bit. Surviving coded bits are packed in time order from out_bits[0] upward, with the first coded bit of each data bit ahead of its second.
- R2: When rate_sel is 0 or 3 on the frame's first beat, every coded bit is kept and out_count equals 2*BEATW.
- R3: When rate_sel is 1, data bits are grouped in pairs by frame position. The second coded bit of the later bit in each pair is deleted, and the other three are kept.
- R4: When rate_sel is 2, data bits are grouped in threes by frame position. Both coded bits of the earliest bit, only the second coded bit of the middle bit and only the first coded bit of the latest bit are kept.
- R5: On every output beat, out_count lies between BEATW and 2*BEATW, and the out_bits positions at and above out_count are zero.
- R6: The deletion-pattern position carries across beats within a frame and restarts at the first data bit of a beat with in_first set.
- R7: The code memory carries across beats and across beats with in_first low. A beat with in_first set is encoded as if all six memory bits were zero.
- R8: While out_valid is high and out_ready is low, out_valid, out_bits and out_count hold steady.
- R9: in_ready is high exactly when out_valid is low or out_ready is high. An accepted beat appears on the output in the next cycle.
- R10: rate_sel is used only on a beat accepted with in_first set. On every other beat its value has no effect on the output.
- R11: After reset, out_valid is low, the code memory is zero, the pattern position is at its start and the rate is 1/2. This state applies to beats sent before any in_first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A data beat is offered |
| in_ready | output | 1 | The block can take a data beat |
| in_bits | input | BEATW | Data bits, bit 0 earliest |
| in_first | input | 1 | Beat starts a frame: clear the memory and the pattern |
| rate_sel | input | 2 | Code rate on the first beat: 0/3 half, 1 two-thirds, 2 three-quarters |
| out_valid | output | 1 | A coded beat is presented |
| out_ready | input | 1 | Downstream takes the coded beat |
| out_bits | output | 2*BEATW | Surviving coded bits, packed from bit 0 |
| out_count | output | clog2(2*BEATW+1) | Number of valid bits in out_bits |

## Verification
Random frames of random length at each rate are compared bit by bit with a one-bit-at-a-time shift-register model that applies deletion afterwards. This separates errors in tap masks, in bit ordering and in packing. With a four-bit beat, the rate-3/4 pattern straddles beat edges, which exposes a phase that is lost or wrongly restarted between beats. An impulse frame, an all-ones frame and back-to-back frames check the generator response and the clearing of the memory. Random values on rate_sel for beats within a frame, random output stalls and a leading beat sent before any in_first cover the rate lock, the output hold and the reset state.

// File: rtl/conv_punct_pkg.sv
package conv_punct_pkg;

  localparam int MEM_LEN = 6;
  // bit d of a mask taps the data bit delayed by d
  localparam logic [MEM_LEN:0] GEN_X = 7'b1101101;  // 133 octal
  localparam logic [MEM_LEN:0] GEN_Y = 7'b1001111;  // 171 octal

  typedef enum logic [1:0] {
    RATE_HALF           = 2'd0,
    RATE_TWO_THIRDS     = 2'd1,
    RATE_THREE_QUARTERS = 2'd2
  } rate_e;

  typedef logic [1:0] phase_t;

  function automatic logic tap_parity(logic [MEM_LEN:0] win, logic [MEM_LEN:0] mask);
    return ^(win & mask);
  endfunction

  function automatic rate_e rate_decode(logic [1:0] sel);
    case (sel)
      2'd1:    return RATE_TWO_THIRDS;
      2'd2:    return RATE_THREE_QUARTERS;
      default: return RATE_HALF;
    endcase
  endfunction

  function automatic phase_t rate_period(rate_e r);
    case (r)
      RATE_TWO_THIRDS:     return 2'd2;
      RATE_THREE_QUARTERS: return 2'd3;
      default:             return 2'd1;
    endcase
  endfunction

  function automatic phase_t phase_step(rate_e r, phase_t ph);
    phase_t nx;
    nx = ph + 2'd1;
    return (nx >= rate_period(r)) ? 2'd0 : nx;
  endfunction

  // second_bit = 0 for the 133 output, 1 for the 171 output
  function automatic logic keep_coded(rate_e r, phase_t ph, logic second_bit);
    case (r)
      RATE_TWO_THIRDS:     return !(ph == 2'd1 && second_bit);
      RATE_THREE_QUARTERS: begin
        if (ph == 2'd0)      return 1'b1;
        else if (ph == 2'd1) return second_bit;
        else                 return !second_bit;
      end
      default:             return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/conv_hist_enc.sv
module conv_hist_enc
  import conv_punct_pkg::*;
#(
  parameter int BEATW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  input  logic               restart,
  input  logic [BEATW-1:0]   bits,
  output logic [2*BEATW-1:0] coded
);

  localparam int HISTW = BEATW + MEM_LEN;

  logic [MEM_LEN-1:0] mem_q;      // mem_q[d-1] = bit delayed by d
  logic [MEM_LEN-1:0] mem_base;
  logic [MEM_LEN-1:0] mem_next;
  logic [HISTW-1:0]   hist;       // hist[MEM_LEN+i] = data bit i

  assign mem_base = restart ? '0 : mem_q;

  always_comb begin
    for (int d = 1; d <= MEM_LEN; d++) hist[MEM_LEN-d] = mem_base[d-1];
    for (int i = 0; i < BEATW; i++)    hist[MEM_LEN+i] = bits[i];
  end

  always_comb begin
    for (int d = 1; d <= MEM_LEN; d++) mem_next[d-1] = hist[HISTW-d];
  end

  for (genvar gi = 0; gi < BEATW; gi++) begin : g_bit
    logic [MEM_LEN:0] win;
    always_comb begin
      for (int d = 0; d <= MEM_LEN; d++) win[d] = hist[gi+MEM_LEN-d];
    end
    assign coded[2*gi]   = tap_parity(win, GEN_X);
    assign coded[2*gi+1] = tap_parity(win, GEN_Y);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mem_q <= '0;
    else if (advance) mem_q <= mem_next;
  end

endmodule

// File: rtl/punct_phase.sv
module punct_phase
  import conv_punct_pkg::*;
#(
  parameter int BEATW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  input  logic               restart,
  input  logic [1:0]         rate_sel,
  output rate_e              rate_eff,
  output rate_e              rate_q,
  output phase_t             phase_q,
  output logic [2*BEATW-1:0] bit_phase
);

  phase_t phase_next;

  assign rate_eff = restart ? rate_decode(rate_sel) : rate_q;

  always_comb begin
    phase_t ph;
    ph = restart ? 2'd0 : phase_q;
    for (int i = 0; i < BEATW; i++) begin
      bit_phase[2*i +: 2] = ph;
      ph = phase_step(rate_eff, ph);
    end
    phase_next = ph;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= RATE_HALF;
      phase_q <= 2'd0;
    end else if (advance) begin
      rate_q  <= rate_eff;
      phase_q <= phase_next;
    end
  end

endmodule

// File: rtl/punct_pack.sv
module punct_pack
  import conv_punct_pkg::*;
#(
  parameter int BEATW = 4,
  localparam int CW   = $clog2(2*BEATW+1)
) (
  input  logic [2*BEATW-1:0] coded,
  input  rate_e              rate_eff,
  input  logic [2*BEATW-1:0] bit_phase,
  output logic [2*BEATW-1:0] packed_bits,
  output logic [CW-1:0]      packed_count
);

  always_comb begin
    int cnt;
    cnt = 0;
    packed_bits = '0;
    for (int j = 0; j < 2*BEATW; j++) begin
      if (keep_coded(rate_eff, bit_phase[2*(j/2) +: 2], j[0])) begin
        packed_bits[cnt] = coded[j];
        cnt = cnt + 1;
      end
    end
    packed_count = CW'(cnt);
  end

endmodule

// File: rtl/conv_punct_enc.sv
module conv_punct_enc
  import conv_punct_pkg::*;
#(
  parameter int BEATW = 4,
  localparam int CW   = $clog2(2*BEATW+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BEATW-1:0]   in_bits,
  input  logic               in_first,
  input  logic [1:0]         rate_sel,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [2*BEATW-1:0] out_bits,
  output logic [CW-1:0]      out_count
);

  logic               fire;
  logic [2*BEATW-1:0] coded;
  logic [2*BEATW-1:0] bit_phase;
  logic [2*BEATW-1:0] packed_bits;
  logic [CW-1:0]      packed_count;
  rate_e              rate_eff;
  rate_e              rate_q;
  phase_t             phase_q;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  conv_hist_enc #(.BEATW(BEATW)) u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (fire),
    .restart (in_first),
    .bits    (in_bits),
    .coded   (coded)
  );

  punct_phase #(.BEATW(BEATW)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (fire),
    .restart   (in_first),
    .rate_sel  (rate_sel),
    .rate_eff  (rate_eff),
    .rate_q    (rate_q),
    .phase_q   (phase_q),
    .bit_phase (bit_phase)
  );

  punct_pack #(.BEATW(BEATW)) u_pack (
    .coded        (coded),
    .rate_eff     (rate_eff),
    .bit_phase    (bit_phase),
    .packed_bits  (packed_bits),
    .packed_count (packed_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bits  <= '0;
      out_count <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_bits  <= packed_bits;
      out_count <= packed_count;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/conv_punct_chk.sv
module conv_punct_chk
  import conv_punct_pkg::*;
#(
  parameter int BEATW = 4,
  localparam int CW   = $clog2(2*BEATW+1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fire,
  input logic               out_valid,
  input logic               out_ready,
  input logic [2*BEATW-1:0] out_bits,
  input logic [CW-1:0]      out_count,
  input rate_e              rate_eff,
  input rate_e              rate_q,
  input phase_t             phase_q
);

  assert_hold_while_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bits) && $stable(out_count));

  assert_load_on_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  assert_count_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count >= CW'(BEATW)) && (out_count <= CW'(2*BEATW)));

  assert_upper_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_bits >> out_count) == '0));

  assert_full_rate_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && rate_eff == RATE_HALF |=> out_count == CW'(2*BEATW));

  assert_phase_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < rate_period(rate_q));

endmodule

bind conv_punct_enc conv_punct_chk #(.BEATW(BEATW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fire      (fire),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bits  (out_bits),
  .out_count (out_count),
  .rate_eff  (rate_eff),
  .rate_q    (rate_q),
  .phase_q   (phase_q)
);

// File: tb/conv_punct_enc_bench.sv
module conv_punct_enc_bench;

  localparam int K  = 4;
  localparam int CW = $clog2(2*K+1);
  localparam int NB = 400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [K-1:0]  in_bits = '0;
  logic          in_first = 1'b0;
  logic [1:0]    rate_sel = 2'd0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [2*K-1:0] out_bits;
  logic [CW-1:0] out_count;

  always #10 clk = ~clk;   // 50 MHz

  conv_punct_enc #(.BEATW(K)) u_conv_punct_enc (
    .clk, .rst_n, .in_valid, .in_ready, .in_bits, .in_first, .rate_sel,
    .out_valid, .out_ready, .out_bits, .out_count
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // stimulus plan
  logic [K-1:0] b_bits  [NB];
  logic         b_first [NB];
  logic [1:0]   b_sel   [NB];
  int           nbeats = 0;

  // bit-serial reference
  logic [5:0] sr;          // sr[k] = bit delayed by k+1
  int         rph;
  int         frate;
  logic       exp_bits[$];
  int         exp_cnt[$];
  int         exp_rate[$];

  function automatic bit keeps(int r, int ph, int w);
    logic [3:0] p23 = 4'b0111;
    logic [5:0] p34 = 6'b011011;
    if (r == 1) return p23[ph*2+w];
    if (r == 2) return p34[ph*2+w];
    return 1'b1;
  endfunction

  task automatic ref_beat(input logic [K-1:0] b, input logic first, input logic [1:0] sel);
    int n;
    logic x, y;
    if (first) begin
      sr = '0; rph = 0;
      frate = (sel == 2'd1) ? 1 : (sel == 2'd2) ? 2 : 0;
    end
    n = 0;
    for (int i = 0; i < K; i++) begin
      x = b[i] ^ sr[1] ^ sr[2] ^ sr[4] ^ sr[5];
      y = b[i] ^ sr[0] ^ sr[1] ^ sr[2] ^ sr[5];
      if (keeps(frate, rph, 0)) begin exp_bits.push_back(x); n++; end
      if (keeps(frate, rph, 1)) begin exp_bits.push_back(y); n++; end
      rph = (rph + 1) % (frate + 1);
      sr = {sr[4:0], b[i]};
    end
    exp_cnt.push_back(n);
    exp_rate.push_back(frate);
  endtask

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic add_frame(input int len, input int kind, input logic [1:0] sel);
    for (int j = 0; j < len && nbeats < NB; j++) begin
      case (kind)
        1:       b_bits[nbeats] = (j == 0) ? K'(1) : '0;   // impulse
        2:       b_bits[nbeats] = '1;
        3:       b_bits[nbeats] = '0;
        default: b_bits[nbeats] = K'($urandom);
      endcase
      b_first[nbeats] = (j == 0);
      // R10: mid-frame rate_sel is random and must be ignored
      b_sel[nbeats] = (j == 0) ? sel : 2'($urandom);
      nbeats++;
    end
  endtask

  function automatic string rtag(int r);
    return (r == 1) ? "R3" : (r == 2) ? "R4" : "R2";
  endfunction

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R11: leading beats before any in_first use zero memory, rate 1/2
    b_bits[0] = 4'b1011; b_first[0] = 1'b0; b_sel[0] = 2'd2;
    b_bits[1] = 4'b0110; b_first[1] = 1'b0; b_sel[1] = 2'd1;
    nbeats = 2;
    add_frame(5, 1, 2'd0);   // R1 impulse response
    add_frame(4, 2, 2'd1);
    add_frame(6, 2, 2'd2);
    add_frame(3, 3, 2'd3);
    add_frame(1, 0, 2'd2);   // single-beat frames back to back (R7)
    add_frame(1, 0, 2'd2);
    while (nbeats < NB - 8) add_frame(1 + int'($urandom % 7), 0, 2'($urandom));
    sr = '0; rph = 0; frate = 0;
  end

  initial begin
    logic [2*K-1:0] held_bits;
    logic [2*K-1:0] ew;
    int idx;
    bit consumed;
    bit was_stalled;
    int n;
    int r;
    idx = 0; consumed = 0; was_stalled = 0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R11 out_valid after reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R11 out_valid idle", out_valid, 0);
    check(in_ready === 1'b1, "R9 in_ready idle", in_ready, 1);
    forever begin
      @(negedge clk);
      // R8: a stalled beat must still be there, unchanged
      if (was_stalled) begin
        check(out_valid === 1'b1 && out_bits === held_bits, "R8 stalled beat held",
              out_bits, held_bits);
      end
      if (!in_valid || consumed) begin
        if (idx < nbeats && ($urandom % 8) != 0) begin
          in_valid = 1'b1; in_bits = b_bits[idx]; in_first = b_first[idx];
          rate_sel = b_sel[idx]; idx++;
        end else begin
          in_valid = 1'b0; in_first = 1'b0; rate_sel = 2'($urandom);
        end
      end
      out_ready = ($urandom % 4) != 0;
      #1;
      check(in_ready === (!out_valid || out_ready), "R9 in_ready", in_ready,
            !out_valid || out_ready);
      was_stalled = out_valid && !out_ready;
      held_bits = out_bits;
      if (out_valid && out_ready) begin
        if (exp_cnt.size() == 0) begin
          check(1'b0, "R9 unexpected output beat", out_bits, 0);
        end else begin
          n = exp_cnt.pop_front();
          r = exp_rate.pop_front();
          ew = '0;
          for (int i = 0; i < n; i++) ew[i] = exp_bits.pop_front();
          check(int'(out_count) == n, {rtag(r), " R5 R6 out_count"}, out_count, n);
          check(out_bits === ew, {rtag(r), " R1 R6 R7 R10 coded bits"}, out_bits, ew);
        end
      end
      if (in_valid && in_ready) begin
        ref_beat(in_bits, in_first, rate_sel);
        consumed = 1;
      end else begin
        consumed = 0;
      end
      if (idx >= nbeats && !in_valid && exp_cnt.size() == 0 && !out_valid) begin
        done = 1;
        summary();
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      summary();
    end
  end

endmodule